// File: doc/BRIEF.md
# Self-Clocking Framed Serializer

This block turns a 10-bit parallel word into a 12-bit serial frame whose boundaries carry a timing reference. A logic-1 start bit comes first. The ten data bits follow, most significant first. A logic-0 stop bit closes the frame. Because every stop bit is directly followed by the next start bit, each frame boundary shows a guaranteed rising edge, and a receiver can recover the bit clock from that edge.

The block runs on one serial-rate clock. A parallel-rate load enable offers words. The load enable is sampled only in an acceptance slot: before the first frame, and in the last bit time of every frame after that. A captured word leaves the serial output one full frame period (12 clocks) after capture. Frames follow each other with no idle bits between them. If a slot passes without a load, the following frame period is sent as all zeros. A debug marker flags the start-bit cycle of each frame.

Top module: `framed_serializer`

## Requirements
- R1: While `rst` is high, and after release until the first frame begins, `ser_out` and `frame_start` are 0.
- R2: Every frame opens with a start bit of 1 on `ser_out`.
- R3: The ten bits after the start bit are `data_in[9]` down to `data_in[0]` of the captured word, in that order.
- R4: The twelfth bit of every frame, the stop bit, is 0.
- R5: The start bit of a captured word appears in the cycle after the 12th rising clock edge that follows the capture edge.
- R6: With a load in every acceptance slot, frames follow each other every 12 clocks with no gap, and every boundary shows 0 followed by 1.
- R7: A `load_en` pulse outside an acceptance slot is ignored: its word never appears on `ser_out`.
- R8: An acceptance slot without a load produces a 12-clock frame period in which `ser_out` and `frame_start` stay 0.
- R9: `frame_start` is 1 exactly in the start-bit cycle of each frame, and 0 otherwise.
- R10: When `load_en` is held high continuously, only the word present in each acceptance slot is sent. Acceptance slots fall once every 12 clocks after the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel-rate word enable |
| data_in | input | 10 | Parallel word to send |
| ser_out | output | 1 | Registered serial data |
| frame_start | output | 1 | High during the start bit of a frame |

## Verification
Alternating patterns (0x155, 0x2AA), all-ones, all-zeros and single-bit words are sent back to back. Together they separate bit order, frame position and boundary polarity: an MSB/LSB swap, a one-bit shift or a wrong stop level each corrupts at least one of them. A word that is read out bit by bit pins down the 12-clock latency. A load pulse placed mid-frame and a skipped slot tell real slot gating apart from capture on any enable. Holding the enable high while the data changes every clock shows which cycle is actually sampled.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;
  localparam logic START_LVL = 1'b1;
  localparam logic STOP_LVL  = 1'b0;

  function automatic int frame_bits(input int word_w);
    return word_w + 2;
  endfunction
endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int FRAME_LEN = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  output logic slot,
  output logic wrap
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic          started;
  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign slot    = !started || at_last;
  assign wrap    = started && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      cnt     <= '0;
    end else if (!started) begin
      if (load_en) begin
        started <= 1'b1;
        cnt     <= '0;
      end
    end else begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/word_hold.sv
module word_hold #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot,
  input  logic              load_en,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] word,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      valid <= 1'b0;
    end else if (slot) begin
      valid <= load_en;
      if (load_en) word <= data_in;
    end
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import ser_frame_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  logic [DATA_W-1:0] word,
  input  logic              valid,
  output logic              ser_out,
  output logic              frame_start
);
  logic [DATA_W:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh          <= '0;
      ser_out     <= STOP_LVL;
      frame_start <= 1'b0;
    end else if (wrap) begin
      if (valid) begin
        sh          <= {word, STOP_LVL};
        ser_out     <= START_LVL;
        frame_start <= 1'b1;
      end else begin
        sh          <= '0;
        ser_out     <= STOP_LVL;
        frame_start <= 1'b0;
      end
    end else begin
      ser_out     <= sh[DATA_W];
      sh          <= {sh[DATA_W-1:0], STOP_LVL};
      frame_start <= 1'b0;
    end
  end
endmodule

// File: rtl/framed_serializer.sv
module framed_serializer
  import ser_frame_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] data_in,
  output logic              ser_out,
  output logic              frame_start
);
  localparam int FRAME_LEN = frame_bits(DATA_W);

  logic              slot;
  logic              wrap;
  logic [DATA_W-1:0] held_word;
  logic              held_valid;

  frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .slot    (slot),
    .wrap    (wrap)
  );

  word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .slot    (slot),
    .load_en (load_en),
    .data_in (data_in),
    .word    (held_word),
    .valid   (held_valid)
  );

  frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .wrap        (wrap),
    .word        (held_word),
    .valid       (held_valid),
    .ser_out     (ser_out),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/framed_serializer_chk.sv
module framed_serializer_chk #(
  parameter int FRAME_LEN = 12
) (
  input logic clk,
  input logic rst,
  input logic ser_out,
  input logic frame_start
);
  localparam int PW = $clog2(FRAME_LEN + 1) + 1;
  localparam logic [PW-1:0] FULL = PW'(FRAME_LEN);
  localparam logic [PW-1:0] STOP_POS = PW'(FRAME_LEN - 1);

  logic [PW-1:0] pos;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      seen <= 1'b0;
    end else if (frame_start) begin
      pos  <= PW'(1);
      seen <= 1'b1;
    end else if (pos < FULL) begin
      pos <= pos + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ser_out && !frame_start));

  assert_start_level_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ser_out);

  assert_stop_level_R4: assert property (@(posedge clk) disable iff (rst)
    (seen && pos == STOP_POS) |-> !ser_out);

  assert_frame_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_start && seen) |-> (pos == FULL));

  assert_boundary_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_start && seen) |-> !$past(ser_out));
endmodule

bind framed_serializer framed_serializer_chk #(.FRAME_LEN(DATA_W + 2)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ser_out     (ser_out),
  .frame_start (frame_start)
);

// File: tb/framed_serializer_bench.sv
`timescale 1ns/1ps
module framed_serializer_bench;
  localparam int DW = 10;
  localparam int FL = DW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          ser_out;
  logic          frame_start;

  framed_serializer #(.DATA_W(DW)) u_framed_serializer (
    .clk         (clk),
    .rst         (rst),
    .load_en     (load_en),
    .data_in     (data_in),
    .ser_out     (ser_out),
    .frame_start (frame_start)
  );

  always #2 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int edges = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_started = 0;
  int          m_ph = 0;
  bit          m_holdv = 0;
  logic [DW-1:0] m_hold = '0;
  bit          qs[$];
  bit          qf[$];
  bit          exp_ser = 0;
  bit          exp_fs = 0;
  bit          at_slot, at_wrap;
  logic [FL-1:0] fr;

  always @(posedge clk) begin
    edges++;
    if (rst) begin
      m_started = 0; m_ph = 0; m_holdv = 0;
      qs.delete(); qf.delete();
      exp_ser = 0; exp_fs = 0;
    end else begin
      at_slot = !m_started || (m_ph == FL - 1);
      at_wrap = m_started && (m_ph == FL - 1);
      if (at_wrap) begin
        fr = {1'b1, m_hold, 1'b0};
        for (int i = 0; i < FL; i++) begin
          qs.push_back(m_holdv ? fr[FL-1-i] : 1'b0);
          qf.push_back(m_holdv && (i == 0));
        end
      end
      if (qs.size() > 0) begin
        exp_ser = qs.pop_front();
        exp_fs  = qf.pop_front();
      end else begin
        exp_ser = 0; exp_fs = 0;
      end
      if (at_slot) begin
        m_holdv = load_en;
        if (load_en) m_hold = data_in;
      end
      if (!m_started) begin
        if (load_en) begin m_started = 1; m_ph = 0; end
      end else begin
        m_ph = (m_ph == FL - 1) ? 0 : m_ph + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done && edges > 0) begin
      compared++;
      if (ser_out !== exp_ser || frame_start !== exp_fs) begin
        mismatched++;
        $display("FAIL %s (R9 marker) t=%0t: ser_out/frame_start=%b%b expected %b%b",
                 cur_req, $time, ser_out, frame_start, exp_ser, exp_fs);
      end
    end
  end

  task automatic check(input bit got, input bit expv, input string req);
    compared++;
    if (got !== expv) begin
      mismatched++;
      $display("FAIL %s t=%0t: got %b expected %b", req, $time, got, expv);
    end
  endtask

  task automatic send_word(input logic [DW-1:0] w);
    @(negedge clk);
    while (!(!m_started || m_ph == FL - 1)) @(negedge clk);
    load_en = 1'b1; data_in = w;
    @(negedge clk);
    load_en = 1'b0; data_in = ~w;
  endtask

  initial begin
    // R1: reset with active enable
    cur_req = "R1";
    load_en = 1'b1; data_in = 10'h3FF;
    repeat (5) @(negedge clk);
    check(ser_out, 1'b0, "R1");
    load_en = 1'b0;
    rst = 1'b0;
    repeat (7) @(negedge clk);
    check(ser_out, 1'b0, "R1");
    check(frame_start, 1'b0, "R1");

    // R5 latency, R2/R3/R4 bit content
    cur_req = "R5";
    send_word(10'h2D5);
    begin
      int n = 0;
      fr = {1'b1, 10'h2D5, 1'b0};
      while (!frame_start && n < 40) begin @(negedge clk); n++; end
      check(n == 12, 1'b1, "R5");
      check(ser_out, 1'b1, "R2");
      for (int i = 1; i < FL; i++) begin
        @(negedge clk);
        check(ser_out, fr[FL-1-i], (i == FL - 1) ? "R4" : "R3");
      end
    end

    // R6 back to back frames with distinct patterns
    cur_req = "R6";
    send_word(10'h3FF); send_word(10'h000); send_word(10'h155);
    send_word(10'h2AA); send_word(10'h001); send_word(10'h200);
    repeat (2 * FL) @(negedge clk);

    // R7 mid-frame pulse ignored
    cur_req = "R7";
    while (!(m_started && m_ph == 4)) @(negedge clk);
    load_en = 1'b1; data_in = 10'h3C3;
    @(negedge clk);
    load_en = 1'b0;
    repeat (3 * FL) @(negedge clk);

    // R8 skipped slot gives a quiet period
    cur_req = "R8";
    send_word(10'h0F0);
    repeat (3 * FL) @(negedge clk);
    check(frame_start, 1'b0, "R8");

    // R10 enable held high with data changing every clock
    cur_req = "R10";
    load_en = 1'b1;
    for (int k = 0; k < 4 * FL; k++) begin
      data_in = DW'(k * 37 + 5);
      @(negedge clk);
    end
    load_en = 1'b0;
    repeat (3 * FL) @(negedge clk);

    // R1 reset mid-frame
    cur_req = "R1";
    send_word(10'h3FF);
    repeat (FL + 3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(ser_out, 1'b0, "R1");
    check(frame_start, 1'b0, "R1");
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(ser_out, 1'b0, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule